// File: doc/BRIEF.md
# Tick-Based Trace Timestamp Inserter

The block sits in a trace message path between a source of trace messages and a single output stream. Incoming trace messages carry no time information. The block adds it by inserting timing markers into the stream. A reader recovers relative time by counting the markers.

While the input is idle, the block counts idle cycles in an internal pending counter. When the next trace message is presented, the block first drains the pending count as single-cycle tick markers, one per output beat, and only then forwards the trace message. When 255 idle cycles have piled up, the block emits one compressed multi-tick marker worth 255 cycles. The counter then starts again from zero. This keeps long quiet periods short in the stored trace.

The output uses a ready/valid handshake. The input uses valid/data with a ready returned, so a trace message is held at the source while markers ahead of it drain. An enable input switches the timing off: the counter is held at zero and trace messages pass straight through.

Top module: `tick_stamper`

## Requirements
- R1: A forwarded trace message appears with `out_kind` = 2'b00 and `out_data` equal to `in_data`, unchanged.
- R2: While enabled, each cycle with `in_valid` low adds one to the pending count. The pending count is emitted as tick markers ahead of the next trace message. A tick marker has `out_kind` = 2'b01 and `out_data` = 0x01. A trace message is only forwarded when the pending count is zero.
- R3: A cycle in which `in_valid` is high does not add to the pending count, including while the trace message waits behind ticks or back-pressure.
- R4: When the pending count reaches 255, a multi-tick marker is emitted before anything else. It has `out_kind` = 2'b10 and `out_data` = 0xFF. After it is accepted, the count restarts from zero. An idle cycle in which the marker is accepted counts as 1.
- R5: When `out_ready` is low, a presented message keeps `out_valid` high with kind and data stable, and the pending count is kept. Once the count is 255 and the marker is not taken, further idle cycles are not counted (saturation).
- R6: With `en` low, the pending count is held at zero and no markers are produced. `out_valid` follows `in_valid`, `out_data` follows `in_data`, and `in_ready` follows `out_ready`.
- R7: `in_ready` is high only in a cycle where the trace message itself is on the output and `out_ready` is high.
- R8: After reset the pending count is zero, so with `in_valid` low `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one tick marker stands for one cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timing enable; low gives plain pass-through |
| in_valid | input | 1 | Trace message presented |
| in_data | input | DATA_W | Trace message payload |
| in_ready | output | 1 | Trace message taken this cycle |
| out_valid | output | 1 | Output message presented |
| out_kind | output | 2 | 00 trace, 01 tick, 10 multi-tick |
| out_data | output | DATA_W | Trace payload, or marker value zero-extended |
| out_ready | input | 1 | Output sink accepts |

## Verification
The inline assertions check properties that hold on every cycle:
- the multi-tick marker wins when the count is full;
- a trace message is never forwarded with ticks still pending;
- each accepted tick removes exactly one count;
- a stalled or disabled cycle leaves the counter alone or zero;
- the input is only acknowledged when the trace message itself is handed over.

Other behaviour only the scoreboard scenarios can show. This covers that the number of markers and their total weight matches the idle gap for gaps below, at and above 255 cycles, and that order holds under output back-pressure. It also covers that saturation discards the overflow cycles, and that disabling gives a stream of bare trace messages.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

    // width of a timing marker and of the pending counter
    parameter int unsigned MARK_W = 8;
    // a multi-tick stands for the largest value the counter can hold
    localparam int unsigned MULTI_SPAN = (1 << MARK_W) - 1;

    typedef enum logic [1:0] {
        KIND_TRACE = 2'b00,
        KIND_TICK  = 2'b01,
        KIND_MULTI = 2'b10
    } msg_kind_e;

    // marker value carried in the low bits of the payload
    function automatic logic [MARK_W-1:0] marker_value(msg_kind_e k);
        logic [MARK_W-1:0] v;
        case (k)
            KIND_TICK:  v = MARK_W'(1);
            KIND_MULTI: v = MARK_W'(MULTI_SPAN);
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tick_accum.sv
module tick_accum
    import tstamp_pkg::*;
#(
    parameter int unsigned CNT_W = MARK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             idle,
    input  logic             take_tick,
    input  logic             take_multi,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero,
    output logic             cnt_full
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        if (take_multi)
            base = '0;
        else if (take_tick)
            base = cnt - CNT_W'(1);
        else
            base = cnt;

        if (!en)
            cnt_nxt = '0;
        else if (idle && base != FULL)
            cnt_nxt = base + CNT_W'(1);
        else
            cnt_nxt = base;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    assign cnt_zero = (cnt == '0);
    assign cnt_full = (cnt == FULL);

    // R4
    multi_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (en && take_multi) |=> (cnt <= CNT_W'(1)));

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && take_tick) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !idle && !take_tick && !take_multi) |=> (cnt == $past(cnt)));

    // R6
    off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_full && !take_multi) |=> (!en || cnt_full));

endmodule

// File: rtl/tick_select.sv
module tick_select
    import tstamp_pkg::*;
(
    input  logic      en,
    input  logic      in_valid,
    input  logic      cnt_zero,
    input  logic      cnt_full,
    input  logic      out_ready,
    output logic      out_valid,
    output msg_kind_e out_kind,
    output logic      in_ready,
    output logic      take_tick,
    output logic      take_multi,
    output logic      idle
);
    logic want_multi;
    logic want_tick;
    logic want_trace;

    always_comb begin
        want_multi = en && cnt_full;
        want_tick  = en && !cnt_full && in_valid && !cnt_zero;
        want_trace = in_valid && (!en || cnt_zero);

        out_valid = want_multi || want_tick || want_trace;
        if (want_multi)
            out_kind = KIND_MULTI;
        else if (want_tick)
            out_kind = KIND_TICK;
        else
            out_kind = KIND_TRACE;

        in_ready   = want_trace && out_ready;
        take_multi = want_multi && out_ready;
        take_tick  = want_tick && out_ready;
        idle       = !in_valid;
    end

endmodule

// File: rtl/tick_stamper.sv
module tick_stamper
    import tstamp_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    localparam int unsigned PAD_W = DATA_W - MARK_W;

    logic [MARK_W-1:0] cnt;
    logic              cnt_zero;
    logic              cnt_full;
    logic              take_tick;
    logic              take_multi;
    logic              idle;
    msg_kind_e         kind;

    tick_accum #(.CNT_W(MARK_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .idle       (idle),
        .take_tick  (take_tick),
        .take_multi (take_multi),
        .cnt        (cnt),
        .cnt_zero   (cnt_zero),
        .cnt_full   (cnt_full)
    );

    tick_select u_select (
        .en         (en),
        .in_valid   (in_valid),
        .cnt_zero   (cnt_zero),
        .cnt_full   (cnt_full),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_kind   (kind),
        .in_ready   (in_ready),
        .take_tick  (take_tick),
        .take_multi (take_multi),
        .idle       (idle)
    );

    assign out_kind = kind;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb
                out_data = (kind == KIND_TRACE) ? in_data
                         : {{PAD_W{1'b0}}, marker_value(kind)};
        end else begin : g_nopad
            always_comb
                out_data = (kind == KIND_TRACE) ? in_data
                         : DATA_W'(marker_value(kind));
        end
    endgenerate

    // R4
    multi_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == {MARK_W{1'b1}}) |-> (out_valid && out_kind == KIND_MULTI));

    // R2
    trace_order_chk: assert property (@(posedge clk) disable iff (rst)
        (en && out_valid && out_kind == KIND_TRACE) |-> (cnt == '0));

    // R7
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (out_ready && out_valid && out_kind == KIND_TRACE));

    // R1
    pass_data_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (out_data == in_data));

endmodule

// File: tb/tb_tick_stamper.sv
`timescale 1ns/1ps
module tb_tick_stamper;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          in_ready;
    logic          out_valid;
    logic [1:0]    out_kind;
    logic [DW-1:0] out_data;
    logic          out_ready;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;   // 0 high, 1 toggling, 2 low
    bit done = 0;

    typedef struct packed { logic [1:0] k; logic [DW-1:0] d; } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    tick_stamper #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_kind(out_kind),
        .out_data(out_data), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [DW-1:0] d);
        item_t it;
        it.k = k;
        it.d = d;
        exp_q.push_back(it);
    endtask

    // R2 R4: gap of idle cycles, then one trace message
    task automatic send(input int gap, input logic [DW-1:0] d, input bit timed);
        if (timed) begin
            for (int i = 0; i < gap / 255; i++) push(2'b10, 16'h00FF);
            for (int i = 0; i < gap % 255; i++) push(2'b01, 16'h0001);
        end
        push(2'b00, d);
        repeat (gap) @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = d;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // output sink
    int tgl = 0;
    always @(posedge clk) begin
        #1;
        tgl++;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = (tgl % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    // monitor / scoreboard
    bit          prev_stall = 0;
    logic [1:0]  prev_k;
    logic [DW-1:0] prev_d;
    int cyc = 0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst && !done) begin
                // R5 stability under back-pressure
                if (prev_stall) begin
                    check(out_valid && out_kind == prev_k && out_data == prev_d,
                          "R5", "held output", {out_kind, out_data}, {prev_k, prev_d});
                end
                // R7 input taken only with trace on output
                if (in_ready)
                    check(out_ready && out_kind == 2'b00 && out_valid, "R7",
                          "in_ready context", out_kind, 0);
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R2", "unexpected output", {out_kind, out_data}, 0);
                    end else begin
                        item_t e;
                        e = exp_q.pop_front();
                        check(out_kind == e.k && out_data == e.d,
                              (e.k == 2'b00) ? "R1" : (e.k == 2'b01 ? "R2" : "R4"),
                              "stream item", {out_kind, out_data}, {e.k, e.d});
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_k = out_kind;
                prev_d = out_data;
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait (cyc > 100000);
        check(0, "R8", "watchdog expired", cyc, 100000);
        finish_run();
    end

    initial begin
        rst = 1'b1; en = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b0, "R8", "in_ready after reset", in_ready, 0);

        // R1 R2 back-to-back and small gaps
        send(0, 16'h1111, 1);
        send(0, 16'h2222, 1);
        send(4, 16'h3333, 1);
        send(1, 16'h4444, 1);
        send(17, 16'h5555, 1);

        // R4 boundaries of compression
        send(254, 16'h6666, 1);
        send(255, 16'h7777, 1);
        send(256, 16'h8888, 1);
        send(510, 16'h9999, 1);
        send(600, 16'hAAAA, 1);

        // R3 R5 back-pressure while ticks drain
        ready_mode = 1;
        send(5, 16'hB001, 1);
        send(9, 16'hB002, 1);
        send(0, 16'hB003, 1);
        send(30, 16'hB004, 1);
        ready_mode = 0;
        repeat (2) @(posedge clk);

        // R5 saturation: sink stalled for a long idle run
        #1 ready_mode = 2; out_ready = 1'b0;
        push(2'b10, 16'h00FF);
        push(2'b00, 16'hC0DE);
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_kind == 2'b10, "R5", "saturated multi shown",
              {out_valid, out_kind}, {1'b1, 2'b10});
        @(posedge clk);
        #1;
        ready_mode = 0; out_ready = 1'b1;
        in_valid = 1'b1; in_data = 16'hC0DE;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;

        // R6 disabled: bare pass-through
        en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R6", "no marker while off", out_valid, 0);
        send(7, 16'hD001, 0);
        send(300, 16'hD002, 0);
        send(0, 16'hD003, 0);
        #1 en = 1'b1;
        send(3, 16'hE001, 1);

        repeat (5) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule